// File: doc/BRIEF.md
# Keyed Super I/O Configuration Decoder

This block holds the configuration space of a multi-function peripheral controller as seen from an 8-bit host I/O bus. The host first opens the space by writing a two-byte key to the configuration port. It then picks one of twelve logical devices and, through an index/data register pair, sets that device's I/O base, interrupt number, DMA channel and activate bit. A final exit key closes the space again.

For every active device the block compares the host I/O address against the programmed base under a per-device alignment mask, and raises that device's select line with no clock delay. Legacy devices keep a compact one-byte base. The other devices keep a full 16-bit base as a high/low byte pair.

Logical device numbers used on the data port at index 0x07: 0 floppy, 1 parallel, 2 serial A, 3 serial B, 4 MIDI, 5 game port, 6 GPIO, 7 watchdog, 8 wake-up, 9 hardware monitor, 10 infrared, 11 ROM.

Top module: `sio_cfg_decoder`

## Requirements
- R1: After reset the space is locked (`cfg_open` low), every device is inactive, every base is zero and `dev_sel` is all zero.
- R2: The space opens only after two back-to-back writes of 0x87 to the index port (`CFG_PORT`). Any other value written to that port between them restarts the key.
- R3: While open, writing 0xAA to the index port locks the space. While locked, data-port writes change no register and data-port reads return 0xFF.
- R4: While open, the index port (`CFG_PORT`) stores the register index and reads it back. The data port (`CFG_PORT`+1) accesses the register at that index in the device chosen by index 0x07. Index 0x07 itself reads back the device number.
- R5: For devices 0 to 3, index 0x60 holds base address bits [9:2] and index 0x61 reads 0xFF.
- R6: For devices 4 to 10, index 0x60 holds the high base byte and index 0x61 holds the low base byte.
- R7: Decode masks: 0x07F8 for devices 0 to 3, 0xFFFC for 4, 0xFFF8 for 5, 0xFFF0 for 6 to 8, and 0xFF00 for 9 and 10.
- R8: `dev_sel[n]` is high, in the same cycle as the address, exactly when device n is active, its base is nonzero and (`io_addr` AND mask) equals (base AND mask).
- R9: Bit 0 of index 0x30 is the activate bit. Clearing it drops the select line but keeps the base, IRQ and DRQ values, which read back unchanged and decode again on re-activation.
- R10: Index 0x70 holds the IRQ for all devices except 5 and 11. Index 0x74 holds the DRQ for devices 0, 1 and 10 only. On a device without the setting, writes are ignored and the index reads 0xFF.
- R11: Device 11 (ROM) has no base register: index 0x60 reads 0xFF and it never raises a select. Unimplemented indexes, and any index of a device number of 12 or more, read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 8 | Read data, 0xFF when not addressed |
| cfg_open | output | 1 | Configuration space is open |
| dev_sel | output | 12 | Per-device I/O select |

## Verification
The hardest case to reach is an access that arrives after the exit key: it must leave every register untouched. Only the port behaviour after the space is reopened can show this. The bench programs the hardware monitor, locks the space, and sends an index write plus a data write that would deactivate the device if they were accepted. It then checks that the monitor still decodes. After reopening the space with the key, it checks that the activate bit reads back as 1. The key restart is reached with the sequence 0x87, 0x11, 0x87. The space must still be locked after that sequence, and must open on the next 0x87.

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder #(
  parameter logic [15:0] CFG_PORT = 16'h002E,
  parameter int          ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [11:0]       dev_sel
);
  localparam int NDEV    = 12;
  localparam int ROM_LDN = 11;
  localparam logic [7:0] KEY_IN  = 8'h87;
  localparam logic [7:0] KEY_OUT = 8'hAA;
  localparam logic [7:0] IX_LDN  = 8'h07;
  localparam logic [7:0] IX_ACT  = 8'h30;
  localparam logic [7:0] IX_BASE = 8'h60;
  localparam logic [7:0] IX_IRQ  = 8'h70;
  localparam logic [7:0] IX_DRQ  = 8'h74;

  function automatic logic short_base(input int n);
    return n < 4;
  endfunction
  function automatic logic has_base(input int n);
    return n < ROM_LDN;
  endfunction
  function automatic logic has_irq(input int n);
    return (n < NDEV) && (n != 5) && (n != ROM_LDN);
  endfunction
  function automatic logic has_drq(input int n);
    return (n == 0) || (n == 1) || (n == 10);
  endfunction
  function automatic logic [15:0] dec_mask(input int n);
    case (n)
      0, 1, 2, 3: return 16'h07F8;
      4:          return 16'hFFFC;
      5:          return 16'hFFF8;
      6, 7, 8:    return 16'hFFF0;
      9, 10:      return 16'hFF00;
      default:    return 16'h0000;
    endcase
  endfunction

  typedef enum logic [1:0] {LOCKED, HALF, OPEN} key_t;
  key_t key_q;

  logic [7:0]      idx_q, ldn_q;
  logic [NDEV-1:0] act_q;
  logic [7:0]      bhi_q [NDEV];
  logic [7:0]      blo_q [NDEV];
  logic [7:0]      irq_q [NDEV];
  logic [7:0]      drq_q [NDEV];

  wire at_idx  = (io_addr == ADDR_W'(CFG_PORT));
  wire at_dat  = (io_addr == ADDR_W'(CFG_PORT + 16'd1));
  wire idx_wr  = io_wr && at_idx;
  wire dat_wr  = io_wr && at_dat && (key_q == OPEN);
  wire ldn_ok  = (ldn_q < 8'(NDEV));
  wire [3:0] cur = ldn_q[3:0];

  assign cfg_open = (key_q == OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= LOCKED;
    end else if (idx_wr) begin
      case (key_q)
        LOCKED:  key_q <= (io_wdata == KEY_IN) ? HALF : LOCKED;
        HALF:    key_q <= (io_wdata == KEY_IN) ? OPEN : LOCKED;
        default: key_q <= (io_wdata == KEY_OUT) ? LOCKED : OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else if (key_q == OPEN && idx_wr && io_wdata != KEY_OUT) begin
      idx_q <= io_wdata;
    end else if (dat_wr && idx_q == IX_LDN) begin
      ldn_q <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      for (int n = 0; n < NDEV; n++) begin
        bhi_q[n] <= 8'h00;
        blo_q[n] <= 8'h00;
        irq_q[n] <= 8'h00;
        drq_q[n] <= 8'h00;
      end
    end else if (dat_wr && ldn_ok) begin
      for (int n = 0; n < NDEV; n++) begin
        if (cur == 4'(n)) begin
          if (idx_q == IX_ACT) act_q[n] <= io_wdata[0];
          if (idx_q == IX_BASE && has_base(n)) bhi_q[n] <= io_wdata;
          if (idx_q == IX_BASE + 8'd1 && has_base(n) && !short_base(n)) blo_q[n] <= io_wdata;
          if (idx_q == IX_IRQ && has_irq(n)) irq_q[n] <= io_wdata;
          if (idx_q == IX_DRQ && has_drq(n)) drq_q[n] <= io_wdata;
        end
      end
    end
  end

  logic [7:0] reg_val;
  always_comb begin
    reg_val = 8'hFF;
    if (idx_q == IX_LDN) begin
      reg_val = ldn_q;
    end else if (ldn_ok) begin
      for (int n = 0; n < NDEV; n++) begin
        if (cur == 4'(n)) begin
          case (idx_q)
            IX_ACT:        reg_val = {7'd0, act_q[n]};
            IX_BASE:       if (has_base(n)) reg_val = bhi_q[n];
            IX_BASE + 8'd1: if (has_base(n) && !short_base(n)) reg_val = blo_q[n];
            IX_IRQ:        if (has_irq(n)) reg_val = irq_q[n];
            IX_DRQ:        if (has_drq(n)) reg_val = drq_q[n];
            default:       reg_val = 8'hFF;
          endcase
        end
      end
    end
  end

  assign io_rdata = !(io_rd && cfg_open) ? 8'hFF :
                    at_idx ? idx_q :
                    at_dat ? reg_val : 8'hFF;

  for (genvar g = 0; g < NDEV; g++) begin : g_dec
    localparam logic [15:0] MASK = dec_mask(g);
    logic [15:0] base;
    if (short_base(g)) begin : g_short
      assign base = {6'd0, bhi_q[g], 2'b00};
    end else begin : g_pair
      assign base = {bhi_q[g], blo_q[g]};
    end
    if (has_base(g)) begin : g_cmp
      assign dev_sel[g] = act_q[g] && (base != 16'd0) &&
                          ((16'(io_addr) & MASK) == (base & MASK));
    end else begin : g_none
      assign dev_sel[g] = 1'b0;
    end

    // R8
    sel_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_sel[g] |-> act_q[g]);
  end

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == KEY_IN));

  // R3
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && at_idx && io_wdata == KEY_OUT) |=> !cfg_open);

  // R3
  locked_act_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(act_q));

  // R3
  locked_ldn_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(ldn_q));

  // R11
  rom_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && cfg_open && idx_q == IX_BASE && ldn_q == 8'(ROM_LDN))
      |-> io_rdata == 8'hFF);
endmodule

// File: tb/sio_cfg_decoder_tb.sv
`timescale 1ns/1ps
module sio_cfg_decoder_tb_top;
  localparam logic [15:0] IXP = 16'h002E;
  localparam logic [15:0] DTP = 16'h002F;
  localparam int NV = 14;
  // {ldn, base, probe, expected select}
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  16'h03F0, 16'h03F7, 1'b1},
    {4'd0,  16'h03F0, 16'h03F8, 1'b0},
    {4'd0,  16'h03F0, 16'h83F0, 1'b1},
    {4'd2,  16'h02F8, 16'h02FF, 1'b1},
    {4'd3,  16'h02E8, 16'h02F0, 1'b0},
    {4'd4,  16'h0330, 16'h0333, 1'b1},
    {4'd4,  16'h0330, 16'h0334, 1'b0},
    {4'd5,  16'h0200, 16'h0207, 1'b1},
    {4'd5,  16'h0200, 16'h0208, 1'b0},
    {4'd6,  16'h1230, 16'h123F, 1'b1},
    {4'd7,  16'h1230, 16'h1240, 1'b0},
    {4'd9,  16'hEC00, 16'hECFF, 1'b1},
    {4'd9,  16'hEC00, 16'hED00, 1'b0},
    {4'd10, 16'h4100, 16'h4155, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0, cfg_open;
  logic [11:0] dev_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_cfg_decoder dut_i (.clk(clk), .rst_n(rst_n), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .cfg_open(cfg_open), .dev_sel(dev_sel));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic setreg(input logic [7:0] ix, input logic [7:0] d);
    wr(IXP, ix); wr(DTP, d);
  endtask

  task automatic rdreg(input logic [7:0] ix, output logic [7:0] d);
    wr(IXP, ix);
    io_addr = DTP; io_rd = 1; #1; d = io_rdata; io_rd = 0;
  endtask

  task automatic probe(input logic [15:0] a);
    io_addr = a; #1;
  endtask

  task automatic prog(input int ldn, input logic [15:0] base);
    setreg(8'h07, 8'(ldn));
    if (ldn < 4) setreg(8'h60, base[9:2]);
    else begin setreg(8'h60, base[15:8]); setreg(8'h61, base[7:0]); end
    setreg(8'h30, 8'h01);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 open", 16'(cfg_open), 0);
    probe(16'h0000);
    check("R1 sel", 16'(dev_sel), 0);
    io_addr = DTP; io_rd = 1; #1;
    check("R3 locked read", 16'(io_rdata), 16'hFF);
    io_rd = 0;
    @(negedge clk);
    // R2 restart on intervening write
    wr(IXP, 8'h87); wr(IXP, 8'h11); wr(IXP, 8'h87);
    check("R2 restart", 16'(cfg_open), 0);
    wr(IXP, 8'h87);
    check("R2 open", 16'(cfg_open), 1);
    // R4 index readback
    wr(IXP, 8'h5A);
    io_addr = IXP; io_rd = 1; #1;
    check("R4 index read", 16'(io_rdata), 16'h5A);
    io_rd = 0;
    @(negedge clk);
    // R7 R8 table
    for (int i = 0; i < NV; i++) begin
      prog(int'(VEC[i][36:33]), VEC[i][32:17]);
      probe(VEC[i][16:1]);
      check($sformatf("R7 R8 vec %0d", i), 16'(dev_sel[VEC[i][36:33]]), 16'(VEC[i][0]));
      @(negedge clk);
    end
    // R5 short base encoding
    setreg(8'h07, 8'd0);
    rdreg(8'h07, r); check("R4 ldn read", 16'(r), 0);
    rdreg(8'h60, r); check("R5 short byte", 16'(r), 16'hFC);
    rdreg(8'h61, r); check("R5 no low byte", 16'(r), 16'hFF);
    // R6 pair encoding
    setreg(8'h07, 8'd9);
    rdreg(8'h60, r); check("R6 high", 16'(r), 16'hEC);
    rdreg(8'h61, r); check("R6 low", 16'(r), 16'h00);
    // R10 irq/drq
    setreg(8'h70, 8'h05);
    rdreg(8'h70, r); check("R10 hwm irq", 16'(r), 16'h05);
    setreg(8'h74, 8'h02);
    rdreg(8'h74, r); check("R10 hwm no drq", 16'(r), 16'hFF);
    setreg(8'h07, 8'd5);
    setreg(8'h70, 8'h03);
    rdreg(8'h70, r); check("R10 game no irq", 16'(r), 16'hFF);
    setreg(8'h07, 8'd0);
    setreg(8'h70, 8'h06); setreg(8'h74, 8'h02);
    rdreg(8'h74, r); check("R10 fdc drq", 16'(r), 16'h02);
    // R9 deactivate keeps settings
    setreg(8'h30, 8'h00);
    probe(16'h03F0);
    check("R9 off sel", 16'(dev_sel[0]), 0);
    rdreg(8'h60, r); check("R9 base kept", 16'(r), 16'hFC);
    rdreg(8'h70, r); check("R9 irq kept", 16'(r), 16'h06);
    setreg(8'h30, 8'h01);
    probe(16'h03F0);
    check("R9 on sel", 16'(dev_sel[0]), 1);
    @(negedge clk);
    // R8 zero base never decodes
    setreg(8'h07, 8'd8);
    setreg(8'h30, 8'h01);
    probe(16'h0000);
    check("R8 zero base", 16'(dev_sel[8]), 0);
    @(negedge clk);
    // R11 ROM and bad ldn
    setreg(8'h07, 8'd11);
    setreg(8'h60, 8'h12); setreg(8'h30, 8'h01);
    rdreg(8'h60, r); check("R11 rom base", 16'(r), 16'hFF);
    probe(16'h1200);
    check("R11 rom sel", 16'(dev_sel[11]), 0);
    @(negedge clk);
    rdreg(8'h22, r); check("R11 unimpl", 16'(r), 16'hFF);
    setreg(8'h07, 8'd13);
    rdreg(8'h30, r); check("R11 bad ldn", 16'(r), 16'hFF);
    // R3 exit and ignored writes
    setreg(8'h07, 8'd9);
    wr(IXP, 8'hAA);
    check("R3 locked", 16'(cfg_open), 0);
    wr(IXP, 8'h30); wr(DTP, 8'h00);
    probe(16'hEC10);
    check("R3 still decodes", 16'(dev_sel[9]), 1);
    @(negedge clk);
    wr(IXP, 8'h87); wr(IXP, 8'h87);
    rdreg(8'h30, r); check("R3 act kept", 16'(r), 16'h01);
    rdreg(8'h07, r); check("R3 ldn kept", 16'(r), 16'h09);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule